// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Sequencer

This block is the digital controller of a 12-bit successive-approximation analog-to-digital converter with a three-wire serial port. A host lowers an active-low select line and toggles a data clock. The block spends a short sample phase, then resolves one result bit per data-clock period. For each step it presents a trial code to an external DAC and comparator and takes back one decision. Each decided bit is shifted out at once on the serial data line. The data line has its own enable that models a high-impedance driver.

The select line and the data clock come from off-chip. Both are synchronised into the system clock and edge-detected, so all logic runs on one clock. After the last bit of the most-significant-first word, the block repeats the word least-significant-first and then sends zeros for as long as the host keeps clocking. Once the last bit is decided, a power-down indication rises even if select stays low. Raising select at any time ends the cycle and returns the sequencer to idle.

Top module: `sar_serial_seq`

## Requirements
- R1: While the select input cs_ni is high, dout_oe_o is 0, pd_o is 1 and trial_o is 0 within SYNC_STAGES+2 clk_i cycles, and data-clock edges have no effect.
- R2: After cs_ni falls, dout_oe_o stays 0 through the first falling data-clock edge. On the second falling edge dout_oe_o becomes 1 and dout_o drives the null bit, logic 0.
- R3: The next twelve falling edges put bits 11 down to 0 of the result on dout_o. The result is the straight binary code found by the search, where comp_i = 1 means the analog input is at or above trial_o.
- R4: dout_o changes only in response to a falling data-clock edge or to cs_ni going high, so it holds steady across every rising data-clock edge.
- R5: On the null-bit edge trial_o becomes 0x800, with only the top bit set. On each later decision edge, the bit under test takes the value of comp_i and the next lower bit is set to 1. After bit 0 is decided, trial_o holds the result.
- R6: If falling edges continue after bit 0, dout_o sends result bits 1 through 11 in that order, then 0 on every further edge while cs_ni stays low.
- R7: pd_o is 0 from the fall of cs_ni until bit 0 is decided. It becomes 1 on the edge that drives bit 0 and stays 1 while cs_ni stays low.
- R8: Raising cs_ni in the middle of a conversion aborts it. The next fall of cs_ni starts a complete, correct sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state is clocked by it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low; high means shutdown |
| sclk_i | input | 1 | Serial data clock from the host |
| comp_i | input | 1 | Comparator decision for the current trial code |
| trial_o | output | 12 | Trial code driven to the DAC |
| dout_o | output | 1 | Serial data |
| dout_oe_o | output | 1 | Serial data driver enable; 0 models high impedance |
| pd_o | output | 1 | Power-down indication |

## Verification
Every result of a data-clock edge is registered after a two-flop synchroniser and an edge detector. dout_o, dout_oe_o, trial_o and pd_o therefore settle three clk_i cycles after the pin moves, and a change on cs_ni shows up after the same delay. The bench holds each half of the data clock for eight clk_i cycles. It reads the outputs on the last cycle of each half, which is well after the results are due and before the next edge. For R4, it compares the value read at the end of the low half with the value read at the end of the high half.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_NULL,
    ST_MSB_OUT,
    ST_LSB_OUT,
    ST_ZERO_OUT
  } seq_state_e;

  typedef enum logic [2:0] {
    OUT_HOLD,
    OUT_NULL,
    OUT_CMP,
    OUT_STORED,
    OUT_ZERO
  } out_sel_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N_BITS = 12,
  parameter int IDX_W  = $clog2(N_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              decide_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] trial_o
);
  localparam logic [N_BITS-1:0] MSB_ONE = {1'b1, {(N_BITS-1){1'b0}}};

  logic [N_BITS-1:0] trial_q, trial_d;

  always_comb begin
    trial_d = trial_q;
    if (clr_i) begin
      trial_d = '0;
    end else if (load_i) begin
      trial_d = MSB_ONE;
    end else if (decide_i) begin
      for (int b = 0; b < N_BITS; b++) begin
        if (b == int'(idx_i))     trial_d[b] = cmp_i;
        if (b + 1 == int'(idx_i)) trial_d[b] = 1'b1;  // arm next lower bit
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trial_q <= '0;
    else         trial_q <= trial_d;
  end

  assign trial_o = trial_q;

  // R5
  msb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (trial_q == MSB_ONE));

  // R1
  trial_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (trial_q == '0));
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 12,
  parameter int IDX_W  = $clog2(N_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fall_i,
  input  out_sel_e          sel_i,
  input  logic              cmp_i,
  input  logic [N_BITS-1:0] trial_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              dout_o,
  output logic              oe_o
);
  logic dout_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (clr_i) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (fall_i) begin
      unique case (sel_i)
        OUT_NULL: begin
          dout_q <= 1'b0;
          oe_q   <= 1'b1;
        end
        OUT_CMP:    dout_q <= cmp_i;
        OUT_STORED: dout_q <= trial_i[idx_i];
        OUT_ZERO:   dout_q <= 1'b0;
        default:    dout_q <= dout_q;
      endcase
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;

  // R4
  dout_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !clr_i) |=> $stable(dout_o));

  // R2
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> !$rose(oe_o));
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int N_BITS       = 12,
  parameter int SAMPLE_EDGES = 2,
  parameter int IDX_W        = $clog2(N_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_hi_i,
  input  logic             cs_fall_i,
  input  logic             sclk_fall_i,
  output logic             pd_o,
  output logic             trial_clr_o,
  output logic             trial_load_o,
  output logic             trial_decide_o,
  output logic [IDX_W-1:0] idx_o,
  output out_sel_e         out_sel_o
);
  localparam int               CNT_W    = $clog2(SAMPLE_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_EDGES - 1);
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(N_BITS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d        = state_q;
    idx_d          = idx_q;
    cnt_d          = cnt_q;
    trial_load_o   = 1'b0;
    trial_decide_o = 1'b0;
    out_sel_o      = OUT_HOLD;
    if (cs_hi_i) begin
      state_d = ST_IDLE;
      idx_d   = '0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cs_fall_i) begin
            state_d = ST_SAMPLE;
            cnt_d   = '0;
          end
        end
        ST_SAMPLE: begin
          if (sclk_fall_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d      = ST_NULL;
              trial_load_o = 1'b1;
              out_sel_o    = OUT_NULL;
              idx_d        = MSB_IDX;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_NULL: begin
          if (sclk_fall_i) begin
            trial_decide_o = 1'b1;
            out_sel_o      = OUT_CMP;
            idx_d          = idx_q - IDX_W'(1);
            state_d        = ST_MSB_OUT;
          end
        end
        ST_MSB_OUT: begin
          if (sclk_fall_i) begin
            trial_decide_o = 1'b1;
            out_sel_o      = OUT_CMP;
            if (idx_q == '0) begin
              state_d = ST_LSB_OUT;
              idx_d   = IDX_W'(1);
            end else begin
              idx_d = idx_q - IDX_W'(1);
            end
          end
        end
        ST_LSB_OUT: begin
          if (sclk_fall_i) begin
            out_sel_o = OUT_STORED;
            if (idx_q == MSB_IDX) state_d = ST_ZERO_OUT;
            else                  idx_d   = idx_q + IDX_W'(1);
          end
        end
        ST_ZERO_OUT: begin
          if (sclk_fall_i) out_sel_o = OUT_ZERO;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  assign trial_clr_o = cs_hi_i;
  assign idx_o       = idx_q;
  // converter is powered only while sampling or resolving
  assign pd_o = (state_q == ST_IDLE) || (state_q == ST_LSB_OUT) ||
                (state_q == ST_ZERO_OUT);

  // R1
  idle_on_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |=> (state_q == ST_IDLE));

  // R6
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZERO_OUT && !cs_hi_i) |=> (state_q == ST_ZERO_OUT));

  // R3
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= MSB_IDX);
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int N_BITS       = 12,
  parameter int SAMPLE_EDGES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              comp_i,
  output logic [N_BITS-1:0] trial_o,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              pd_o
);
  localparam int IDX_W = $clog2(N_BITS);

  logic             cs_hi, cs_fall, sclk_lvl, sclk_fall;
  logic             trial_clr, trial_load, trial_decide;
  logic [IDX_W-1:0] idx;
  out_sel_e         out_sel;
  logic [N_BITS-1:0] trial;

  sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni),
    .level_o(cs_hi), .fall_o(cs_fall)
  );

  sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i),
    .level_o(sclk_lvl), .fall_o(sclk_fall)
  );

  sar_seq_fsm #(.N_BITS(N_BITS), .SAMPLE_EDGES(SAMPLE_EDGES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_hi_i(cs_hi), .cs_fall_i(cs_fall), .sclk_fall_i(sclk_fall),
    .pd_o(pd_o), .trial_clr_o(trial_clr), .trial_load_o(trial_load),
    .trial_decide_o(trial_decide), .idx_o(idx), .out_sel_o(out_sel)
  );

  sar_trial_reg #(.N_BITS(N_BITS)) u_trial (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(trial_clr), .load_i(trial_load),
    .decide_i(trial_decide), .idx_i(idx), .cmp_i(comp_i), .trial_o(trial)
  );

  sar_out_stage #(.N_BITS(N_BITS)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(trial_clr), .fall_i(sclk_fall),
    .sel_i(out_sel), .cmp_i(comp_i), .trial_i(trial), .idx_i(idx),
    .dout_o(dout_o), .oe_o(dout_oe_o)
  );

  assign trial_o = trial;

  // R4
  sclk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_lvl && !cs_hi) |=> $stable(dout_o));
endmodule

// File: tb/sar_serial_seq_tb.sv
`timescale 1ns/1ps
module sar_serial_seq_tb;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] vin = '0;
  logic        comp;
  logic [11:0] trial_o;
  logic        dout, oe, pd;
  int          checks = 0;
  int          errors = 0;
  int          r4_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign comp = (vin >= trial_o);

  sar_serial_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk),
    .comp_i(comp), .trial_o(trial_o), .dout_o(dout),
    .dout_oe_o(oe), .pd_o(pd)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one data-clock period; R4 compares dout at end of low vs end of high half
  task automatic pulse();
    logic pre;
    pre  = dout;
    sclk = 1'b1;
    wait_clk(HALF);
    if (dout !== pre) r4_bad++;
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic check_idle(input string req);
    check(oe == 1'b0, {req, " oe"}, oe, 0);
    check(pd == 1'b1, {req, " pd"}, pd, 1);
    check(trial_o == 12'h000, {req, " trial"}, trial_o, 0);
  endtask

  task automatic t_reset();
    check_idle("R1 reset");
    check(dout == 1'b0, "R1 reset dout", dout, 0);
  endtask

  task automatic t_cs_high_clocks();
    for (int i = 0; i < 5; i++) pulse();
    check_idle("R1 clocks while cs high");
  endtask

  task automatic t_conversion(input logic [11:0] v);
    logic [11:0] msb_word, lsb_word;
    int pd_early;
    int zero_bad;
    vin = v;
    r4_bad = 0;
    pd_early = 0;
    zero_bad = 0;
    cs_ni = 1'b0;
    wait_clk(HALF);
    pulse();
    check(oe == 1'b0, "R2 oe after first edge", oe, 0);
    check(pd == 1'b0, "R7 pd during sample", pd, 0);
    pulse();
    check(oe == 1'b1 && dout == 1'b0, "R2 null bit", {oe, dout}, 2'b10);
    check(trial_o == 12'h800, "R5 msb load", trial_o, 12'h800);
    for (int i = 11; i >= 0; i--) begin
      pulse();
      msb_word[i] = dout;
      if (i == 11)
        check(trial_o == ((v & 12'h800) | 12'h400), "R5 first step", trial_o,
              (v & 12'h800) | 12'h400);
      if (i > 0 && pd) pd_early++;
    end
    check(msb_word == v, "R3 msb-first word", msb_word, v);
    check(trial_o == v, "R5 final trial", trial_o, v);
    check(pd_early == 0, "R7 pd low while resolving", pd_early, 0);
    check(pd == 1'b1, "R7 pd at bit 0", pd, 1);
    lsb_word[0] = msb_word[0];
    for (int i = 1; i < 12; i++) begin
      pulse();
      lsb_word[i] = dout;
    end
    check(lsb_word == v, "R6 lsb-first word", lsb_word, v);
    for (int i = 0; i < 3; i++) begin
      pulse();
      if (dout !== 1'b0 || pd !== 1'b1 || oe !== 1'b1) zero_bad++;
    end
    check(zero_bad == 0, "R6 trailing zeros", zero_bad, 0);
    check(r4_bad == 0, "R4 stable across rising edge", r4_bad, 0);
    cs_ni = 1'b1;
    wait_clk(6);
    check_idle("R1 after cs high");
  endtask

  task automatic t_abort();
    vin = 12'h5A5;
    cs_ni = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 6; i++) pulse();
    check(pd == 1'b0, "R8 mid-conversion pd", pd, 0);
    cs_ni = 1'b1;
    wait_clk(6);
    check_idle("R8 abort");
    t_conversion(12'h3C7);
  endtask

  initial begin
    wait_clk(4);
    rst_ni = 1'b1;
    wait_clk(4);
    t_reset();
    t_cs_high_clocks();
    t_conversion(12'hA5C);
    t_conversion(12'h000);
    t_conversion(12'hFFF);
    t_conversion(12'h801);
    t_abort();
    t_conversion(12'h7FF);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule